// File: doc/BRIEF.md
# Banked Memory Crossbar Arbiter

This block lets the load/store issue ports of a wide-issue core share one word-addressed data store. The store is split into independent single-ported banks. It is not built as a single multi-ported array. Every port connects to every bank through a crossbar. The low word-address bits pick the bank, and the remaining bits pick the row inside that bank. When requests in one cycle go to different banks, all of them are serviced in that same cycle.

The compiler normally arranges memory operations so that no two of them meet on one bank. When that assumption breaks, each bank grants the lowest-numbered contender and stalls the others. A combinational conflict flag tells the machine that its static schedule was violated in this cycle. A saturating counter totals the cycles lost to such collisions, which exposes hot banks. A stalled port keeps its request asserted until it is granted. Writes land in the grant cycle. Read data comes back on the requesting port's own return lane one cycle after the grant.

Top module: `bmx_xbar`

## Requirements
- R1: The bank index is the lowest log2(NBANK) bits of a port's word address, and the rest of the address is the row inside that bank. Two addresses that differ only in row bits use different storage in the same bank.
- R2: When the valid requests of a cycle all target different banks, every one of them is granted in that cycle and no stall is raised.
- R3: Among requests that target one bank in the same cycle, the lowest-numbered port is granted and every other contender sees its stall bit at 1. Each bank grants at most one port per cycle.
- R4: A port's stall bit is 1 only when that port presents a valid request that is not granted. An idle port always reads stall 0.
- R5: A granted write updates the bank row at the clock edge that ends its grant cycle. A read granted in a later cycle returns the new value.
- R6: A read granted in cycle t raises rd_valid for that port in cycle t+1, with the row's content on that port's rd_data lane. A granted write raises no rd_valid.
- R7: A stalled request has no effect. A stalled write leaves memory unchanged, and a stalled read produces no rd_valid in the next cycle.
- R8: conflict is 1 in exactly those cycles in which two or more valid requests target the same bank.
- R9: conflict_count goes up by one at each clock edge that ends a cycle with conflict at 1. It holds otherwise, and it saturates at its all-ones value.
- R10: After reset, rd_valid is all 0 and conflict_count is 0.
- R11: A group of ports that hold their colliding requests until granted is served one port per cycle, in ascending port order. Each request is granted exactly once, so none is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | NPORT | Request present, one bit per port |
| req_write | input | NPORT | 1 = write, 0 = read, per port |
| req_addr | input | NPORT*AW | Word address per port, port p at bits [p*AW +: AW] |
| req_wdata | input | NPORT*DW | Write data per port, port p at bits [p*DW +: DW] |
| stall | output | NPORT | Request not granted this cycle; hold it |
| rd_valid | output | NPORT | Read data present on the port's lane |
| rd_data | output | NPORT*DW | Read data per port, port p at bits [p*DW +: DW] |
| conflict | output | 1 | Two or more requests target one bank this cycle |
| conflict_count | output | CW | Saturating count of conflict cycles |

## Verification
The bench instantiates the block with four ports and four banks, a 6-bit word address (sixteen rows per bank), 16-bit data and a 3-bit conflict counter. With four banks and four ports, every collision pattern can occur, from all ports on one bank to fully disjoint traffic. The small counter width means saturation at 7 is reached after only a few colliding cycles. Each granted access is compared against a flat 64-word model. Reads of held requests are counted per port to show that each one is served exactly once.

// File: rtl/bmx_pkg.sv
package bmx_pkg;

    // Widest port vector the shared helpers handle.
    localparam int MAXP = 32;

    // Keeps only the lowest set bit of a request vector.
    function automatic logic [MAXP-1:0] lowest_set(input logic [MAXP-1:0] v);
        return v & (~v + MAXP'(1));
    endfunction

endpackage

// File: rtl/bmx_bank_arb.sv
module bmx_bank_arb
    import bmx_pkg::*;
#(
    parameter int NPORT = 4
) (
    input  logic [NPORT-1:0] hit,
    output logic [NPORT-1:0] gnt,
    output logic             clash
);

    // Fixed priority: the lowest port number wins the bank.
    always_comb begin
        gnt   = NPORT'(lowest_set(MAXP'(hit)));
        clash = ($countones(hit) > 1);
    end

endmodule

// File: rtl/bmx_bank_ram.sv
module bmx_bank_ram #(
    parameter int ROWW = 6,
    parameter int DW   = 32
) (
    input  logic            clk,
    input  logic            en,
    input  logic            we,
    input  logic [ROWW-1:0] row,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata
);

    localparam int DEPTH = 1 << ROWW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[row] <= wdata;
            end else begin
                rdata <= mem[row];
            end
        end
    end

endmodule

// File: rtl/bmx_xbar.sv
module bmx_xbar #(
    parameter int NPORT = 4,
    parameter int NBANK = 4,
    parameter int AW    = 8,
    parameter int DW    = 32,
    parameter int CW    = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NPORT-1:0]    req_valid,
    input  logic [NPORT-1:0]    req_write,
    input  logic [NPORT*AW-1:0] req_addr,
    input  logic [NPORT*DW-1:0] req_wdata,
    output logic [NPORT-1:0]    stall,
    output logic [NPORT-1:0]    rd_valid,
    output logic [NPORT*DW-1:0] rd_data,
    output logic                conflict,
    output logic [CW-1:0]       conflict_count
);

    localparam int BW   = $clog2(NBANK);
    localparam int ROWW = AW - BW;

    // Per-port decode of the flat request buses.
    logic [BW-1:0]   p_bank  [NPORT];
    logic [ROWW-1:0] p_row   [NPORT];
    logic [DW-1:0]   p_wdata [NPORT];

    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            p_bank[p]  = req_addr[p*AW +: BW];
            p_row[p]   = req_addr[p*AW + BW +: ROWW];
            p_wdata[p] = req_wdata[p*DW +: DW];
        end
    end

    logic [NBANK*NPORT-1:0] gnt_flat;
    logic [NBANK-1:0]       clash;
    logic [NBANK*DW-1:0]    b_rdata;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [NPORT-1:0] hit;
        logic             en;
        logic             we;
        logic [ROWW-1:0]  row;
        logic [DW-1:0]    wd;

        always_comb begin
            for (int p = 0; p < NPORT; p++) begin
                hit[p] = req_valid[p] && (p_bank[p] == BW'(b));
            end
        end

        bmx_bank_arb #(.NPORT(NPORT)) u_arb (
            .hit   (hit),
            .gnt   (gnt_flat[b*NPORT +: NPORT]),
            .clash (clash[b])
        );

        // Forward path of the crossbar: the winner drives the bank.
        always_comb begin
            en  = 1'b0;
            we  = 1'b0;
            row = '0;
            wd  = '0;
            for (int p = 0; p < NPORT; p++) begin
                if (gnt_flat[b*NPORT + p]) begin
                    en  = 1'b1;
                    we  = req_write[p];
                    row = p_row[p];
                    wd  = p_wdata[p];
                end
            end
        end

        bmx_bank_ram #(.ROWW(ROWW), .DW(DW)) u_ram (
            .clk   (clk),
            .en    (en),
            .we    (we),
            .row   (row),
            .wdata (wd),
            .rdata (b_rdata[b*DW +: DW])
        );
    end

    logic [NPORT-1:0] granted;

    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            granted[p] = gnt_flat[int'(p_bank[p])*NPORT + p];
        end
        stall    = req_valid & ~granted;
        conflict = |clash;
    end

    // Return path: remember which bank each granted read used.
    logic [NPORT*BW-1:0] rsel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid       <= '0;
            rsel_q         <= '0;
            conflict_count <= '0;
        end else begin
            for (int p = 0; p < NPORT; p++) begin
                rd_valid[p]         <= granted[p] && !req_write[p];
                rsel_q[p*BW +: BW] <= p_bank[p];
            end
            if (conflict && (conflict_count != {CW{1'b1}})) begin
                conflict_count <= conflict_count + CW'(1);
            end
        end
    end

    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            rd_data[p*DW +: DW] = rd_valid[p]
                ? b_rdata[int'(rsel_q[p*BW +: BW])*DW +: DW]
                : '0;
        end
    end

endmodule

// File: rtl/bmx_xbar_chk.sv
module bmx_xbar_chk #(
    parameter int NPORT = 4,
    parameter int NBANK = 4,
    parameter int AW    = 8,
    parameter int CW    = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NPORT-1:0]    req_valid,
    input logic [NPORT-1:0]    req_write,
    input logic [NPORT*AW-1:0] req_addr,
    input logic [NPORT-1:0]    stall,
    input logic [NPORT-1:0]    rd_valid,
    input logic                conflict,
    input logic [CW-1:0]       conflict_count
);

    localparam int BW = $clog2(NBANK);

    a_r3_port0_never_waits: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid[0] |-> !stall[0]);

    a_r3_conflict_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |-> (stall != '0));

    a_r8_lone_request_clean: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(req_valid) < 2) |-> !conflict);

    a_r9_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (conflict && (conflict_count != {CW{1'b1}}))
        |=> (conflict_count == CW'($past(conflict_count) + CW'(1))));

    a_r9_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !conflict |=> $stable(conflict_count));

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        a_r4_stall_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
            stall[p] |-> req_valid[p]);

        a_r6_read_returns: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[p] && !stall[p] && !req_write[p]) |=> rd_valid[p]);

        a_r7_no_spurious_return: assert property (@(posedge clk) disable iff (!rst_n)
            !(req_valid[p] && !stall[p] && !req_write[p]) |=> !rd_valid[p]);
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [NPORT-1:0] won;
        always_comb begin
            for (int p = 0; p < NPORT; p++) begin
                won[p] = req_valid[p] && !stall[p] && (req_addr[p*AW +: BW] == BW'(b));
            end
        end
        a_r3_one_winner_per_bank: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(won) <= 1);
    end

endmodule

bind bmx_xbar bmx_xbar_chk #(
    .NPORT (NPORT),
    .NBANK (NBANK),
    .AW    (AW),
    .CW    (CW)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_write      (req_write),
    .req_addr       (req_addr),
    .stall          (stall),
    .rd_valid       (rd_valid),
    .conflict       (conflict),
    .conflict_count (conflict_count)
);

// File: tb/sim_bmx_xbar.sv
module sim_bmx_xbar;

    localparam int PERIOD = 10;
    localparam int NP = 4;
    localparam int NB = 4;
    localparam int AWB = 6;
    localparam int DWB = 16;
    localparam int CWB = 3;
    localparam int NV = 9;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NP-1:0]       req_valid = '0;
    logic [NP-1:0]       req_write = '0;
    logic [NP*AWB-1:0]   req_addr = '0;
    logic [NP*DWB-1:0]   req_wdata = '0;
    logic [NP-1:0]       stall;
    logic [NP-1:0]       rd_valid;
    logic [NP*DWB-1:0]   rd_data;
    logic                conflict;
    logic [CWB-1:0]      conflict_count;

    always #(PERIOD/2) clk = ~clk;

    bmx_xbar #(.NPORT(NP), .NBANK(NB), .AW(AWB), .DW(DWB), .CW(CWB)) u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_write      (req_write),
        .req_addr       (req_addr),
        .req_wdata      (req_wdata),
        .stall          (stall),
        .rd_valid       (rd_valid),
        .rd_data        (rd_data),
        .conflict       (conflict),
        .conflict_count (conflict_count)
    );

    // Vector: {valid, write, addr3, addr2, addr1, addr0, expected stall, expected conflict}
    // Address = row*4 + bank (R1).
    localparam logic [36:0] VEC [NV] = '{
        {4'b1111, 4'b1111, 6'h0F, 6'h0A, 6'h05, 6'h00, 4'b0000, 1'b0},
        {4'b1111, 4'b1111, 6'h10, 6'h0C, 6'h08, 6'h04, 4'b1110, 1'b1},
        {4'b1111, 4'b0000, 6'h00, 6'h0F, 6'h0A, 6'h05, 4'b0000, 1'b0},
        {4'b1010, 4'b1010, 6'h16, 6'h00, 6'h12, 6'h00, 4'b1000, 1'b1},
        {4'b1100, 4'b0000, 6'h04, 6'h12, 6'h00, 6'h00, 4'b0000, 1'b0},
        {4'b1111, 4'b1001, 6'h03, 6'h0A, 6'h05, 6'h01, 4'b0010, 1'b1},
        {4'b0000, 4'b0000, 6'h00, 6'h00, 6'h00, 6'h00, 4'b0000, 1'b0},
        {4'b1100, 4'b0000, 6'h03, 6'h0F, 6'h00, 6'h00, 4'b1000, 1'b1},
        {4'b0011, 4'b0000, 6'h00, 6'h00, 6'h03, 6'h01, 4'b0000, 1'b0}
    };

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    int exp_cnt = 0;
    logic [DWB-1:0] model [64];
    bit known [64];
    logic [NP-1:0] last_stall;
    int rdv_cnt [NP];

    task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    // Fixed-priority rule, computed from the requirements.
    function automatic logic [NP-1:0] pri_stall(input logic [NP-1:0] v, input logic [NP*AWB-1:0] a);
        logic [NP-1:0] s = '0;
        for (int p = 0; p < NP; p++) begin
            for (int q = 0; q < p; q++) begin
                if (v[p] && v[q] && (a[p*AWB +: 2] == a[q*AWB +: 2])) s[p] = 1'b1;
            end
        end
        return s;
    endfunction

    task automatic step(input logic [NP-1:0] v, input logic [NP-1:0] w,
                        input logic [NP*AWB-1:0] a, input logic [NP*DWB-1:0] d,
                        input logic [NP-1:0] es, input logic ec, input string tag);
        logic [NP-1:0]  exp_rv = '0;
        logic [NP-1:0]  chk_rd = '0;
        logic [DWB-1:0] exp_rd [NP];
        @(negedge clk);
        req_valid = v;
        req_write = w;
        req_addr  = a;
        req_wdata = d;
        #1;
        check(stall == es, {tag, " stall mask (R3, R4, R2)"}, 64'(stall), 64'(es));
        check(conflict == ec, {tag, " conflict flag R8"}, 64'(conflict), 64'(ec));
        last_stall = stall;
        for (int p = 0; p < NP; p++) begin
            exp_rd[p] = '0;
            if (v[p] && !es[p] && !w[p]) begin
                exp_rv[p] = 1'b1;
                exp_rd[p] = model[a[p*AWB +: AWB]];
                chk_rd[p] = known[a[p*AWB +: AWB]];
            end
        end
        for (int p = 0; p < NP; p++) begin
            if (v[p] && !es[p] && w[p]) begin
                model[a[p*AWB +: AWB]] = d[p*DWB +: DWB];
                known[a[p*AWB +: AWB]] = 1'b1;
            end
        end
        if (ec && exp_cnt != 7) exp_cnt++;
        @(posedge clk);
        #1;
        check(rd_valid == exp_rv, {tag, " rd_valid R6"}, 64'(rd_valid), 64'(exp_rv));
        for (int p = 0; p < NP; p++) begin
            if (chk_rd[p]) begin
                check(rd_data[p*DWB +: DWB] == exp_rd[p], {tag, " rd_data R5"},
                      64'(rd_data[p*DWB +: DWB]), 64'(exp_rd[p]));
            end
            rdv_cnt[p] += int'(rd_valid[p]);
        end
        check(conflict_count == CWB'(exp_cnt), {tag, " conflict_count R9"},
              64'(conflict_count), 64'(exp_cnt));
    endtask

    task automatic dstep(input logic [NP-1:0] v, input logic [NP-1:0] w,
                         input logic [NP*AWB-1:0] a, input logic [NP*DWB-1:0] d, input string tag);
        logic [NP-1:0] s;
        s = pri_stall(v, a);
        step(v, w, a, d, s, |s, tag);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 20000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [NP*DWB-1:0] d;
        logic [NP*AWB-1:0] a;
        logic [NP-1:0] pend;
        int cyc;
        int gcount [NP];
        for (int i = 0; i < 64; i++) known[i] = 1'b0;
        for (int p = 0; p < NP; p++) rdv_cnt[p] = 0;

        repeat (3) @(negedge clk);
        #1;
        check(rd_valid == '0, "R10 rd_valid in reset", 64'(rd_valid), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(rd_valid == '0, "R10 rd_valid after reset", 64'(rd_valid), 64'(0));
        check(conflict_count == '0, "R10 conflict_count after reset", 64'(conflict_count), 64'(0));
        check(stall == '0, "R4 idle stall", 64'(stall), 64'(0));

        // Table walk (R1, R2, R3, R5, R6, R8, R9).
        for (int i = 0; i < NV; i++) begin
            for (int p = 0; p < NP; p++) d[p*DWB +: DWB] = {4'(i), 4'(p), 8'h5A};
            step(VEC[i][36:33], VEC[i][32:29], VEC[i][28:5], d, VEC[i][4:1], VEC[i][0],
                 $sformatf("vec%0d", i));
        end

        // R7: a stalled write leaves memory alone, a stalled read returns nothing.
        dstep(4'b0001, 4'b0001, {6'h00, 6'h00, 6'h00, 6'h21}, {48'h0, 16'h1111}, "R7 setup");
        dstep(4'b0101, 4'b0101, {6'h00, 6'h21, 6'h00, 6'h25},
              {16'h0, 16'h2222, 16'h0, 16'h3333}, "R7 stalled write");
        dstep(4'b1000, 4'b0000, {6'h21, 6'h00, 6'h00, 6'h00}, '0, "R7 readback");
        dstep(4'b0011, 4'b0001, {6'h00, 6'h00, 6'h2D, 6'h29}, {48'h0, 16'h4444}, "R7 stalled read");

        // R11: held writes to one bank are served once each, in port order.
        a = {6'h36, 6'h32, 6'h2E, 6'h2A};
        d = {16'hD3D3, 16'hC2C2, 16'hB1B1, 16'hA0A0};
        pend = 4'b1111;
        cyc = 0;
        for (int p = 0; p < NP; p++) gcount[p] = 0;
        while (pend != 0 && cyc < 8) begin
            dstep(pend, 4'b1111, a, d, "R11 held write");
            for (int p = 0; p < NP; p++) begin
                if (pend[p] && !last_stall[p]) begin
                    gcount[p]++;
                    pend[p] = 1'b0;
                end
            end
            cyc++;
        end
        check(cyc == 4, "R11 write drain cycles", 64'(cyc), 64'(4));
        for (int p = 0; p < NP; p++) check(gcount[p] == 1, "R11 write grants per port", 64'(gcount[p]), 64'(1));

        // R11: held reads in reversed order, each returns once.
        a = {6'h2A, 6'h2E, 6'h32, 6'h36};
        pend = 4'b1111;
        cyc = 0;
        for (int p = 0; p < NP; p++) rdv_cnt[p] = 0;
        while (pend != 0 && cyc < 8) begin
            dstep(pend, 4'b0000, a, '0, "R11 held read");
            for (int p = 0; p < NP; p++) if (pend[p] && !last_stall[p]) pend[p] = 1'b0;
            cyc++;
        end
        dstep(4'b0000, 4'b0000, '0, '0, "R11 drain");
        for (int p = 0; p < NP; p++) check(rdv_cnt[p] == 1, "R11 read returns per port", 64'(rdv_cnt[p]), 64'(1));

        // R1: two rows of bank 3 hold distinct values.
        dstep(4'b0001, 4'b0001, {18'h0, 6'h07}, {48'h0, 16'h7777}, "R1 row a");
        dstep(4'b0001, 4'b0001, {18'h0, 6'h0B}, {48'h0, 16'hBBBB}, "R1 row b");
        dstep(4'b0011, 4'b0000, {12'h0, 6'h0B, 6'h07}, '0, "R1 rows read");

        // R9: saturation of the conflict counter.
        for (int k = 0; k < 8; k++) begin
            dstep(4'b0011, 4'b0011, {12'h0, 6'h3F, 6'h3B}, {32'h0, 16'h0F0F, 16'hF0F0}, "R9 collide");
        end
        check(conflict_count == 3'd7, "R9 saturated", 64'(conflict_count), 64'(7));
        dstep(4'b0000, 4'b0000, '0, '0, "R9 hold");
        check(conflict_count == 3'd7, "R9 stays saturated", 64'(conflict_count), 64'(7));

        summary();
    end

endmodule